// File: doc/BRIEF.md
# Prescaled Timer with Compare-Reset Mode

This block is a free-running up-counter for timing work inside a larger chip. The bus clock is divided by a selectable power of two, and each divided tick advances the counter by one. A single compare channel watches the counter and raises its own sticky flag when it meets the programmed value. When the counter-reset enable is on, a compare hit sends the counter back to zero, so the block acts as a modulus counter. A sticky overflow flag marks the natural wrap from all ones to zero. An interrupt request follows that flag when its enable is set.

Software-side logic writes a one on a bit of the clear strobe to clear the matching flag. A newly chosen division does not take effect at once. It is held back until the internal divider chain passes through zero, so no tick comes out early or as a fragment. The external reset is asynchronous and active low, and it is released through a two-stage synchronizer.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the counter is 0, both flags are 0 and the interrupt request is 0. The third rising clock edge after `rst_ni` rises is the first functional edge (k=1).
- R2: With the counter-reset enable at 0 and select value s held from reset, the counter reads floor(k/2^s) mod 2^CNT_W after k functional edges, for every s from 0 to 2^SEL_W-1.
- R3: An internal divider of 2^SEL_W-1 bits counts bus edges modulo 2^(2^SEL_W-1). It starts at 0 when reset releases and is cleared by a compare reset. A new select value is applied only on an edge where this divider is 0, and the previous division stays in force until then.
- R4: With the counter-reset enable at 0, the counter wraps from all ones to 0 on a tick, and a compare hit has no effect on the count.
- R5: With the counter-reset enable at 1 and a compare value C other than 0, the counter reaches C, returns to 0 on the next bus edge and restarts the divider. The count after k edges is floor((k mod P)/2^s), with a period P = C*2^s + 1.
- R6: With the counter-reset enable at 1 and a compare value of 0, the counter stays at 0.
- R7: With the counter-reset enable at 1 and a compare value of all ones, the overflow flag is never set.
- R8: The overflow flag is set on the tick that carries the free-running counter from all ones to 0.
- R9: The compare flag is set on the bus edge after the counter has been updated to a value equal to the compare input.
- R10: `flag_clr_i` bit 0 clears the compare flag and bit 1 clears the overflow flag. A 0 bit leaves its flag unchanged, and a set on the same edge as a clear wins.
- R11: `irq_o` is 1 exactly when the overflow interrupt enable and the overflow flag are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | SEL_W | Division select: divide by 2^psel_i |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| cnt_rst_en_i | input | 1 | Reset the counter on a compare hit |
| cmp_i | input | CNT_W | Compare value |
| flag_clr_i | input | 2 | Write-one clear: bit 0 compare flag, bit 1 overflow flag |
| cnt_o | output | CNT_W | Counter value |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky compare flag |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with CNT_W=8 and the default SEL_W=3. An 8-bit counter makes the all-ones wrap, and full modulus periods with a compare value of all ones, reachable within a few hundred ticks for every division. This in turn lets the bench sweep all eight prescale settings, with the expected counts taken from floor and modulo arithmetic. Because the divider has 7 stages, it passes through zero every 128 edges, so the deferred select change can be seen in a short run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int FLG_N   = 2;
  localparam int FLG_CMP = 0;
  localparam int FLG_OVF = 1;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, mask;
  logic [SEL_W-1:0] sel_q, sel_eff;
  logic             at_zero;

  // New select is honoured only when every divider stage is zero.
  always_comb begin
    at_zero = (div_q == '0);
    sel_eff = at_zero ? sel_i : sel_q;
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(sel_eff));
    tick_o  = &(div_q | ~mask);
    div_d   = restart_i ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sel_q <= '0;
    end else begin
      div_q <= div_d;
      if (at_zero) sel_q <= sel_i;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cre_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             wrap_o,
  output logic             restart_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fresh_q, cnt_en;

  // fresh_q marks a counter value written on the previous edge.
  always_comb begin
    hit_o     = fresh_q && (cnt_q == cmp_i);
    restart_o = cre_i && hit_o;
    wrap_o    = tick_i && !restart_o && (&cnt_q);
    cnt_en    = restart_o || tick_i;
    cnt_d     = restart_o ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fresh_q <= 1'b1;
    end else begin
      fresh_q <= cnt_en;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FLG_N-1:0] set_i,
  input  logic [FLG_N-1:0] clr_i,
  output logic [FLG_N-1:0] flag_o
);
  for (genvar g = 0; g < FLG_N; g++) begin : g_flag
    logic flg_q, flg_d;
    always_comb flg_d = set_i[g] || (flg_q && !clr_i[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flg_q <= 1'b0;
      else         flg_q <= flg_d;
    end
    assign flag_o[g] = flg_q;
  end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] psel_i,
  input  logic             ovf_ie_i,
  input  logic             cnt_rst_en_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [1:0]       flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_flag_o,
  output logic             cmp_flag_o,
  output logic             irq_o
);
  logic             rst_sync_n, tick, hit, wrap, restart;
  logic [FLG_N-1:0] flg_set, flg;

  tmr_rst_sync i_rst_sync (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_sync_n));

  tmr_prescaler #(.SEL_W(SEL_W)) i_presc (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .sel_i(psel_i),
    .restart_i(restart), .tick_o(tick));

  tmr_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .tick_i(tick), .cre_i(cnt_rst_en_i),
    .cmp_i(cmp_i), .cnt_o(cnt_o), .hit_o(hit), .wrap_o(wrap), .restart_o(restart));

  always_comb begin
    flg_set          = '0;
    flg_set[FLG_CMP] = hit;
    flg_set[FLG_OVF] = wrap;
  end

  tmr_flags i_flags (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .set_i(flg_set),
    .clr_i(flag_clr_i), .flag_o(flg));

  assign cmp_flag_o = flg[FLG_CMP];
  assign ovf_flag_o = flg[FLG_OVF];
  assign irq_o      = ovf_ie_i && ovf_flag_o;
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             cre,
  input logic             wrap,
  input logic             ovf_flag,
  input logic [1:0]       clr
);
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == $past(cnt) + CNT_W'(1)) || (cnt == '0)); // R2

  AST_OVF_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(ovf_flag) |-> (cnt == '0) && (&$past(cnt))); // R8

  AST_MOD_RESET: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((cnt == '0) && ($past(cnt) != '0) && !(&$past(cnt))) |-> $past(cre)); // R5

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_n)
    wrap |=> ovf_flag); // R10

  AST_CLEAR_OVF: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ovf_flag && clr[1] && !wrap) |=> !ovf_flag); // R10
endmodule

bind prescaled_timer prescaled_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_n(rst_sync_n), .cnt(cnt_o), .cre(cnt_rst_en_i),
  .wrap(wrap), .ovf_flag(ovf_flag_o), .clr(flag_clr_i));

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
  localparam int TCLK  = 10;
  localparam int CW    = 8;
  localparam int SW    = 3;
  localparam int TOP   = (1 << CW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [SW-1:0] psel_i;
  logic          ovf_ie_i, cnt_rst_en_i;
  logic [CW-1:0] cmp_i;
  logic [1:0]    flag_clr_i;
  logic [CW-1:0] cnt_o;
  logic          ovf_flag_o, cmp_flag_o, irq_o;

  int checks = 0;
  int errs   = 0;

  always #(TCLK/2) clk_i = ~clk_i;

  prescaled_timer #(.CNT_W(CW), .SEL_W(SW)) i_prescaled_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .ovf_ie_i(ovf_ie_i),
    .cnt_rst_en_i(cnt_rst_en_i), .cmp_i(cmp_i), .flag_clr_i(flag_clr_i),
    .cnt_o(cnt_o), .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o), .irq_o(irq_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic restart(input int s, input logic cre, input int cmp);
    @(negedge clk_i);
    rst_ni = 1'b0; psel_i = SW'(s); cnt_rst_en_i = cre; cmp_i = CW'(cmp);
    ovf_ie_i = 1'b0; flag_clr_i = 2'b00;
    adv(2);
    rst_ni = 1'b1;
    adv(2);
  endtask

  initial begin
    #(TCLK * 190000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    restart(2, 1'b0, 100);
    chk("R1 cnt", cnt_o, 0);
    chk("R1 ovf", ovf_flag_o, 0);
    chk("R1 cmpf", cmp_flag_o, 0);
    chk("R1 irq", irq_o, 0);

    // R2 free-run division sweep over every select value
    for (int s = 0; s < 8; s++) begin
      restart(s, 1'b0, 0);
      for (int k = 1; k <= 300; k++) begin
        adv(1);
        chk($sformatf("R2 s=%0d k=%0d", s, k), cnt_o, (k >> s) % (TOP + 1));
      end
    end

    // R4 / R8 overflow on free-running wrap
    for (int s = 0; s < 4; s++) begin
      restart(s, 1'b0, 3);
      adv(((TOP + 1) << s) - 1);
      chk($sformatf("R4 cnt top s=%0d", s), cnt_o, TOP);
      chk($sformatf("R8 ovf before wrap s=%0d", s), ovf_flag_o, 0);
      adv(1);
      chk($sformatf("R4 cnt wrap s=%0d", s), cnt_o, 0);
      chk($sformatf("R8 ovf at wrap s=%0d", s), ovf_flag_o, 1);
    end

    // R11 interrupt gating (overflow flag is set here)
    chk("R11 irq inhibited", irq_o, 0);
    ovf_ie_i = 1'b1; #1;
    chk("R11 irq asserted", irq_o, 1);
    flag_clr_i = 2'b10; adv(1); flag_clr_i = 2'b00; #1;
    chk("R11 irq after clear", irq_o, 0);
    chk("R10 ovf cleared", ovf_flag_o, 0);

    // R10 set wins, zero bit no effect
    restart(0, 1'b0, 200);
    adv(254);
    flag_clr_i = 2'b10;
    adv(2);
    chk("R10 set wins over clear", ovf_flag_o, 1);
    flag_clr_i = 2'b01; adv(1);
    chk("R10 zero bit leaves ovf", ovf_flag_o, 1);
    flag_clr_i = 2'b10; adv(1);
    chk("R10 ovf write-one clear", ovf_flag_o, 0);
    flag_clr_i = 2'b00;

    // R9 compare flag timing
    restart(0, 1'b0, 48);
    adv(48);
    chk("R9 cmpf not yet", cmp_flag_o, 0);
    adv(1);
    chk("R9 cmpf set", cmp_flag_o, 1);
    chk("R4 no reset when disabled", cnt_o, 49);
    flag_clr_i = 2'b01; adv(1); flag_clr_i = 2'b00;
    chk("R10 cmpf cleared", cmp_flag_o, 0);
    restart(2, 1'b0, 5);
    adv(20);
    chk("R9 cmpf s2 not yet", cmp_flag_o, 0);
    adv(1);
    chk("R9 cmpf s2 set", cmp_flag_o, 1);

    // R3 deferred select change
    restart(3, 1'b0, 0);
    adv(20);
    psel_i = 3'd0;
    adv(80);
    chk("R3 old division kept k=100", cnt_o, 12);
    adv(28);
    chk("R3 old division kept k=128", cnt_o, 16);
    adv(2);
    chk("R3 new division k=130", cnt_o, 18);

    // R5 modulus counting
    for (int t = 0; t < 4; t++) begin
      int s, c, p;
      s = t;
      c = (t == 0) ? 5 : (t == 1) ? 3 : (t == 2) ? 7 : 2;
      p = c * (1 << s) + 1;
      restart(s, 1'b1, c);
      for (int k = 1; k <= 3 * p + 5; k++) begin
        adv(1);
        chk($sformatf("R5 s=%0d c=%0d k=%0d", s, c, k), cnt_o, (k % p) >> s);
      end
    end

    // R6 compare value zero holds the counter
    restart(2, 1'b1, 0);
    for (int k = 1; k <= 60; k++) begin
      adv(1);
      chk($sformatf("R6 k=%0d", k), cnt_o, 0);
    end

    // R7 all-ones compare never sets overflow
    for (int s = 0; s < 2; s++) begin
      int p;
      p = TOP * (1 << s) + 1;
      restart(s, 1'b1, TOP);
      for (int k = 1; k <= 2 * p + 10; k++) begin
        adv(1);
        if (k % 64 == 0 || k == p) chk($sformatf("R5 top s=%0d k=%0d", s, k), cnt_o, (k % p) >> s);
      end
      chk($sformatf("R7 ovf s=%0d", s), ovf_flag_o, 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule